// File: doc/BRIEF.md
# LCD Column Scan and Drive-Level Selector

This block keeps a bit-mapped image for one column side of a dot-matrix LCD. By default it holds 160 display lines of 240 pixels each. A host writes pixel bytes through an 8-bit port. The port has an address pointer that the host loads and that then advances by itself after each write. Host writes run independently of the display scan. A stored 1 is a lit pixel and a stored 0 is a dark pixel.

The scan side is driven by a line clock and a frame pulse, both sampled in the system clock domain. On each falling edge of the line clock, one whole row is copied from memory into a column latch, and the line pointer moves on. When the frame pulse is high at that edge, the scan restarts at line 0. Each latched bit is combined with the live frame polarity and an active-low display-off input. The result is a 2-bit drive-level code for every column. The analog stage downstream turns that code into one of four voltages.

The scan controller has two states. SC_BLANK is entered on reset. In SC_BLANK the latch is held clear and every column shows the rest level. The only transition, SC_BLANK to SC_SHOW, happens on the first falling edge of the line clock. SC_SHOW is then kept until the next reset.

Top module: `lcd_col_driver`

## Requirements
- R1: While reset is held, and after reset until the first line-clock falling edge, every column code is 00. This holds whatever the frame polarity is.
- R2: A cycle with `host_addr_ld` high loads the write pointer from `host_line`/`host_byte`. Any write requested in that same cycle is ignored. Otherwise each `host_wr` cycle stores `host_data` at the pointer and then advances the pointer. The byte advances from 29 to 0 while the line increments. The line wraps from 159 back to 0.
- R3: Byte `k` of a line covers columns 8k to 8k+7. Data bit 7 maps to column 8k and data bit 0 maps to column 8k+7. A stored 1 is a lit pixel.
- R4: At a line-clock falling edge, the row captured is line 0 if `frame_pulse` is high. Otherwise it is the current line pointer. The pointer then becomes the captured line plus one, wrapping from 159 to 0.
- R5: The column latch changes only at a line-clock falling edge. A host write to the line being shown does not alter the outputs before the next falling edge.
- R6: When a host write and a row capture touch the same byte in the same cycle, the capture takes the data that was there before the write.
- R7: While `disp_off_n` is low, every column code is 00, whatever the frame polarity and the latched data are.
- R8: While showing with display-off inactive, the code depends on polarity and pixel. Polarity 0 with a dark pixel gives 01, and polarity 0 with a lit pixel gives 00. Polarity 1 with a dark pixel gives 10, and polarity 1 with a lit pixel gives 11. The output follows `frame_pol` without waiting for a line-clock edge. Column `c` occupies bits `col_lvl[2c+1:2c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr_ld | input | 1 | Load the write pointer |
| host_line | input | 8 | Line to load into the pointer |
| host_byte | input | 5 | Byte within the line to load into the pointer |
| host_wr | input | 1 | Write one pixel byte at the pointer |
| host_data | input | 8 | Pixel byte, bit 7 is the leftmost column |
| line_clk | input | 1 | Line clock; its falling edge captures a row |
| frame_pulse | input | 1 | When high at a falling edge, restarts the scan at line 0 |
| frame_pol | input | 1 | AC drive polarity of the current frame |
| disp_off_n | input | 1 | Forces the rest level on all columns when low |
| col_lvl | output | 480 | Two-bit drive code per column |

## Verification
The bench fills the whole memory through a single pointer load. This exercises every byte and line wrap of the pointer. A pointer that failed to wrap, or that advanced on a load cycle, would leave a row with the wrong bytes. It runs a full 160-line pass with no frame pulse, so a counter that stopped at 159 or skipped line 0 would show the wrong row. It also times a host write into the byte being captured. A design that forwarded the new byte into the latch would light the wrong column. Toggling polarity and display-off with no line-clock edge checks that outputs follow the live inputs while the latch holds still. The frame-pulse restart is checked at line 0, and bit-to-column order is checked by single-column probes.

// File: rtl/lcd_col_pkg.sv
package lcd_col_pkg;

    // Symbolic drive levels; the analog stage decodes them.
    typedef enum logic [1:0] {
        LVL_REST    = 2'b00,  // ground-side / lowest bias
        LVL_NEG_MID = 2'b01,  // dark pixel, polarity 0
        LVL_POS_MID = 2'b10,  // dark pixel, polarity 1
        LVL_PEAK    = 2'b11   // lit pixel, polarity 1
    } drive_lvl_e;

    typedef enum logic {
        SC_BLANK = 1'b0,
        SC_SHOW  = 1'b1
    } scan_state_e;

    function automatic drive_lvl_e pick_level(input logic pol, input logic lit);
        drive_lvl_e lv;
        unique case ({pol, lit})
            2'b00:   lv = LVL_NEG_MID;
            2'b01:   lv = LVL_REST;
            2'b10:   lv = LVL_POS_MID;
            default: lv = LVL_PEAK;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/lcd_pix_store.sv
module lcd_pix_store #(
    parameter int LINES = 160,
    parameter int COLS  = 240,
    parameter int DW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        addr_ld,
    input  logic [$clog2(LINES)-1:0]    ld_line,
    input  logic [$clog2(COLS/DW)-1:0]  ld_byte,
    input  logic                        wr_en,
    input  logic [DW-1:0]               wr_data,
    input  logic [$clog2(LINES)-1:0]    rd_line,
    output logic [COLS-1:0]             rd_row
);
    localparam int BPL = COLS / DW;
    localparam int LW  = $clog2(LINES);
    localparam int BW  = $clog2(BPL);
    localparam int CW  = $clog2(COLS);

    logic [COLS-1:0] mem [LINES];
    logic [LW-1:0]   wr_line;
    logic [BW-1:0]   wr_byte;
    logic            do_wr;

    assign do_wr = wr_en && !addr_ld;

    // Row-wide memory, byte-wide write; bit DW-1 lands on the lowest column.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            for (int b = 0; b < DW; b++) begin
                mem[wr_line][CW'(int'(wr_byte) * DW + (DW - 1 - b))] <= wr_data[b];
            end
        end
    end

    // Asynchronous read: a same-cycle write is not yet visible (old data).
    assign rd_row = mem[rd_line];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_line <= '0;
            wr_byte <= '0;
        end else if (addr_ld) begin
            wr_line <= ld_line;
            wr_byte <= ld_byte;
        end else if (wr_en) begin
            if (wr_byte == BW'(BPL - 1)) begin
                wr_byte <= '0;
                wr_line <= (wr_line == LW'(LINES - 1)) ? '0 : wr_line + 1'b1;
            end else begin
                wr_byte <= wr_byte + 1'b1;
            end
        end
    end

    a_r2_byte_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_byte < BW'(BPL));
    a_r2_line_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_line < LW'(LINES));
    a_r2_byte_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && wr_byte == BW'(BPL - 1)) |=> (wr_byte == '0));
    a_r2_load_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ld && wr_en) |=> (wr_byte == $past(ld_byte) && wr_line == $past(ld_line)));

endmodule

// File: rtl/lcd_line_scan.sv
module lcd_line_scan
    import lcd_col_pkg::*;
#(
    parameter int LINES = 160,
    parameter int COLS  = 240
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_clk,
    input  logic                      frame_pulse,
    output logic [$clog2(LINES)-1:0]  rd_line,
    input  logic [COLS-1:0]           rd_row,
    output logic [COLS-1:0]           row_latch,
    output logic                      showing
);
    localparam int LW = $clog2(LINES);

    scan_state_e    state, state_nx;
    logic           clk_q;
    logic           fall;
    logic [LW-1:0]  line_ptr;

    assign fall    = clk_q && !line_clk;
    assign rd_line = frame_pulse ? '0 : line_ptr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SC_BLANK;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            SC_BLANK: if (fall) state_nx = SC_SHOW;
            SC_SHOW:  state_nx = SC_SHOW;
        endcase
    end

    // Outputs
    always_comb begin
        showing = (state == SC_SHOW);
    end

    // Line counter and column latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q     <= 1'b0;
            line_ptr  <= '0;
            row_latch <= '0;
        end else begin
            clk_q <= line_clk;
            if (fall) begin
                row_latch <= rd_row;
                line_ptr  <= (rd_line == LW'(LINES - 1)) ? '0 : rd_line + 1'b1;
            end
        end
    end

    a_r4_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        line_ptr < LW'(LINES));
    a_r4_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && frame_pulse) |=> (line_ptr == LW'(1)));
    a_r1_blank_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SC_BLANK) |-> (row_latch == '0));
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(row_latch));

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
    import lcd_col_pkg::*;
#(
    parameter int COLS = 240
) (
    input  logic [COLS-1:0]    row_latch,
    input  logic               showing,
    input  logic               pol,
    input  logic               off_n,
    output logic [2*COLS-1:0]  lvl
);
    for (genvar g = 0; g < COLS; g++) begin : g_col
        always_comb begin
            if (!off_n || !showing) lvl[2*g +: 2] = LVL_REST;
            else                    lvl[2*g +: 2] = pick_level(pol, row_latch[g]);
        end
    end
endmodule

// File: rtl/lcd_col_driver.sv
module lcd_col_driver #(
    parameter int LINES = 160,
    parameter int COLS  = 240,
    parameter int DW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_addr_ld,
    input  logic [$clog2(LINES)-1:0]    host_line,
    input  logic [$clog2(COLS/DW)-1:0]  host_byte,
    input  logic                        host_wr,
    input  logic [DW-1:0]               host_data,
    input  logic                        line_clk,
    input  logic                        frame_pulse,
    input  logic                        frame_pol,
    input  logic                        disp_off_n,
    output logic [2*COLS-1:0]           col_lvl
);
    localparam int LW = $clog2(LINES);

    logic [LW-1:0]   rd_line;
    logic [COLS-1:0] rd_row;
    logic [COLS-1:0] row_latch;
    logic            showing;

    lcd_pix_store #(.LINES(LINES), .COLS(COLS), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_ld (host_addr_ld),
        .ld_line (host_line),
        .ld_byte (host_byte),
        .wr_en   (host_wr),
        .wr_data (host_data),
        .rd_line (rd_line),
        .rd_row  (rd_row)
    );

    lcd_line_scan #(.LINES(LINES), .COLS(COLS)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_clk    (line_clk),
        .frame_pulse (frame_pulse),
        .rd_line     (rd_line),
        .rd_row      (rd_row),
        .row_latch   (row_latch),
        .showing     (showing)
    );

    lcd_level_map #(.COLS(COLS)) u_map (
        .row_latch (row_latch),
        .showing   (showing),
        .pol       (frame_pol),
        .off_n     (disp_off_n),
        .lvl       (col_lvl)
    );

    a_r7_off_forces_rest: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_off_n |-> (col_lvl == '0));
    a_r1_rest_until_show: assert property (@(posedge clk) disable iff (!rst_n)
        !showing |-> (col_lvl == '0));

endmodule

// File: tb/lcd_col_driver_tb.sv
module lcd_col_driver_tb;
    localparam int L   = 160;
    localparam int C   = 240;
    localparam int BPL = 30;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_addr_ld = 1'b0;
    logic [7:0]     host_line = '0;
    logic [4:0]     host_byte = '0;
    logic           host_wr = 1'b0;
    logic [7:0]     host_data = '0;
    logic           line_clk = 1'b0;
    logic           frame_pulse = 1'b0;
    logic           frame_pol = 1'b0;
    logic           disp_off_n = 1'b1;
    logic [2*C-1:0] col_lvl;

    always #4 clk = ~clk;

    lcd_col_driver u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr_ld(host_addr_ld), .host_line(host_line),
        .host_byte(host_byte), .host_wr(host_wr), .host_data(host_data),
        .line_clk(line_clk), .frame_pulse(frame_pulse), .frame_pol(frame_pol),
        .disp_off_n(disp_off_n), .col_lvl(col_lvl)
    );

    int total = 0;
    int bad = 0;
    string tag = "R1";
    bit done = 1'b0;

    // Behavioural reference model
    bit [7:0]  ref_mem [int];
    bit        m_clq, m_show;
    int        m_ptr, m_wl, m_wb;
    bit [C-1:0] m_latch;

    function automatic bit [7:0] rd_ref(int k);
        return ref_mem.exists(k) ? ref_mem[k] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clq = 0; m_show = 0; m_ptr = 0; m_wl = 0; m_wb = 0; m_latch = '0;
        end else begin
            if (m_clq && !line_clk) begin
                int cap;
                cap = frame_pulse ? 0 : m_ptr;
                for (int c = 0; c < C; c++) begin
                    bit [7:0] by;
                    by = rd_ref(cap * BPL + c / 8);
                    m_latch[c] = by[7 - (c % 8)];
                end
                m_show = 1;
                m_ptr = (cap + 1) % L;
            end
            m_clq = line_clk;
            if (host_addr_ld) begin
                m_wl = int'(host_line); m_wb = int'(host_byte);
            end else if (host_wr) begin
                ref_mem[m_wl * BPL + m_wb] = host_data;
                m_wb = m_wb + 1;
                if (m_wb == BPL) begin m_wb = 0; m_wl = (m_wl + 1) % L; end
            end
        end
    end

    function automatic bit [1:0] ref_code(bit pol, bit lit);
        case ({pol, lit})
            2'b00: return 2'b01;
            2'b01: return 2'b00;
            2'b10: return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    // Every-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            logic [2*C-1:0] exp_v;
            for (int c = 0; c < C; c++) begin
                if (!rst_n || !disp_off_n || !m_show) exp_v[2*c +: 2] = 2'b00;
                else exp_v[2*c +: 2] = ref_code(frame_pol, m_latch[c]);
            end
            total++;
            if (col_lvl !== exp_v) begin
                bad++;
                $display("FAIL %s per-clock compare: actual=%h expected=%h", tag, col_lvl, exp_v);
            end
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic chk_col(string t, int c, logic [1:0] e);
        total++;
        if (col_lvl[2*c +: 2] !== e) begin
            bad++;
            $display("FAIL %s column %0d: actual=%b expected=%b", t, c, col_lvl[2*c +: 2], e);
        end
    endtask

    task automatic chk_all_rest(string t);
        total++;
        if (col_lvl !== '0) begin
            bad++;
            $display("FAIL %s all columns rest: actual=%h expected=0", t, col_lvl);
        end
    endtask

    task automatic lpulse(bit fp);
        line_clk = 1; frame_pulse = fp; tick(); tick();
        line_clk = 0; tick();
        frame_pulse = 0; tick();
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_up();
    end

    initial begin
        // R1: reset and blank state
        tag = "R1";
        repeat (3) tick();
        chk_all_rest("R1");
        rst_n = 1; tick();
        frame_pol = 1; line_clk = 1; tick(); tick();
        chk_all_rest("R1");

        // R2: fill whole memory through one pointer load
        tag = "R2";
        host_addr_ld = 1; host_line = 0; host_byte = 0; tick();
        host_addr_ld = 0; host_wr = 1;
        for (int i = 0; i < L * BPL; i++) begin
            host_data = 8'((i * 37 + 5) & 255); tick();
        end
        host_wr = 0; tick();
        // end-of-memory wrap lands on line 0 byte 0
        host_addr_ld = 1; host_line = 159; host_byte = 29; tick();
        host_addr_ld = 0; host_wr = 1; host_data = 8'hA5; tick();
        host_data = 8'h3C; tick();
        // R2: load and write together -> write ignored
        host_addr_ld = 1; host_line = 5; host_byte = 0; host_data = 8'hFF; tick();
        host_addr_ld = 0; host_wr = 0; tick();
        chk_all_rest("R1");

        // R4 frame restart, R3 bit order
        tag = "R4";
        lpulse(1);
        frame_pol = 1; tick();
        chk_col("R3", 0, 2'b10);   // byte 0x3C bit7=0 dark
        chk_col("R3", 2, 2'b11);   // bit5=1 lit
        tag = "R8";
        frame_pol = 0; tick();
        chk_col("R8", 0, 2'b01);
        chk_col("R8", 2, 2'b00);

        // R4: full pass without frame pulse, wrap 159 -> 0
        tag = "R4";
        for (int p = 0; p < L; p++) lpulse(0);
        chk_col("R4", 0, 2'b01);
        chk_col("R4", 2, 2'b00);

        // R5: write to the shown line does not alter outputs
        tag = "R5";
        host_addr_ld = 1; host_line = 0; host_byte = 0; tick();
        host_addr_ld = 0; host_wr = 1; host_data = 8'hFF; tick();
        host_wr = 0; tick(); tick();
        chk_col("R5", 0, 2'b01);

        // R6: same-cycle write and capture of line 1 byte 0 (old 0x5B)
        tag = "R6";
        host_addr_ld = 1; host_line = 1; host_byte = 0; tick();
        host_addr_ld = 0; line_clk = 1; tick(); tick();
        line_clk = 0; host_wr = 1; host_data = 8'h00; tick();
        host_wr = 0; tick();
        chk_col("R6", 1, 2'b00);   // old bit6=1 -> lit
        chk_col("R6", 0, 2'b01);

        // R7: display off overrides everything
        tag = "R7";
        disp_off_n = 0; tick();
        chk_all_rest("R7");
        frame_pol = 1; tick();
        chk_all_rest("R7");
        disp_off_n = 1; tick();
        chk_col("R8", 1, 2'b11);

        // R8: polarity toggles with no line-clock edge
        tag = "R8";
        for (int k = 0; k < 6; k++) begin frame_pol = ~frame_pol; tick(); end
        lpulse(1); lpulse(0);
        tick();
        finish_up();
    end
endmodule